// File: doc/BRIEF.md
# Slot Hotplug Register Controller

This block keeps the hotplug bookkeeping for up to 32 bus slots and exposes it to firmware through a 16-byte window of 32-bit registers. Per-slot strobes report devices that arrive after boot, devices that are asked to leave, and devices found at boot. A per-slot mask marks the slots whose devices can never be removed. The block holds three bitmaps: which slots hold a device, which slots are removable, and which slots wait for removal. Firmware reads these bitmaps and writes a slot mask to eject one slot at a time. The block answers with a one-clock eject pulse on that slot's line. Hot-add and hot-remove events raise a one-clock pulse, which the surrounding logic uses to set the hotplug bit of its general-purpose event status. Device teardown and interrupt generation are outside the block.

The register port is a plain select/write strobe with a registered read return. `rd_valid` rises in the cycle after every read select. There is no back-pressure: the block accepts every access in the cycle it is presented. A synchronous `soft_rst`, and the release of `rst_n`, start a flush. The flush ejects every pending slot, lowest slot first, one slot per cycle. The cycle after the flush ends, the removable bitmap is reloaded from the non-removable mask.

Top module: `hp_slot_ctrl`

## Requirements
- R1: An access takes effect only if `bus_be` is 4'hF and `bus_addr[1:0]` is 0. A write that fails this test changes nothing. A read that fails it still returns `rd_valid` and data zero. Every read select gives `rd_valid` high, with its data, in the next cycle.
- R2: A read at offset 0x0 returns the bitwise AND of the present bitmap and the removable bitmap. Bit i stands for slot i.
- R3: A read at offset 0x4 returns the pending-removal bitmap.
- R4: A read at offset 0x8 returns zero. A full-word write at 0x8 selects the lowest set bit of `bus_wdata` and clears that slot's pending bit at the write edge. `eject_o` then carries that single bit for the following cycle.
- R5: An eject clears the slot's present bit only when the slot is removable. A non-removable slot stays present.
- R6: A read at offset 0xC returns the removable bitmap. Writes at 0x0, 0x4 and 0xC are ignored.
- R7: A hot-add strobe sets the present bit of its slot. `gpe_hp_o` pulses in the next cycle.
- R8: A hot-remove strobe sets the pending bit of its slot. `gpe_hp_o` pulses in the next cycle.
- R9: A cold-plug strobe sets the present bit and produces no `gpe_hp_o` pulse.
- R10: After `soft_rst`, or after `rst_n` is released, every pending slot is ejected, lowest first, one per cycle. During this flush, eject writes are ignored. The removable bitmap then becomes the inverse of `non_removable`, and the present bitmap keeps what the flush left.
- R11: An eject write whose slot mask is zero changes no state and gives no pulse.
- R12: `eject_o` has at most one bit set in any cycle, and each pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the bitmaps and starts a flush |
| soft_rst | input | 1 | Synchronous platform reset request; starts a flush and rebuild |
| hot_add | input | 32 | Per-slot hot-add strobes |
| hot_rm | input | 32 | Per-slot hot-remove strobes |
| cold_plug | input | 32 | Per-slot boot-presence strobes |
| non_removable | input | 32 | Per-slot mask of devices that cannot be removed |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset in the window |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read return strobe, one cycle after the select |
| eject_o | output | 32 | One-clock eject pulse on the selected slot |
| gpe_hp_o | output | 1 | One-clock hotplug event pulse |

## Verification
The bench writes an eject mask with two bits set and checks that only the lower slot pulses. A design that served the highest bit, or all set bits, would pulse the wrong slot or several slots at once. It ejects a non-removable slot, makes that slot removable, and reruns the flush. The slot then shows as present, which a design that cleared present on every eject would not show. It also checks that a zero mask, a partial-byte write, a misaligned write and a write during a flush all leave the pending bitmap unchanged and give no pulse. It checks that the flush pulses the pending slots in ascending order. A design that dropped the ignore rules would show stray pulses or changed bitmaps. A design that flushed in the wrong order would show the pulses out of sequence.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int WIN_AW = 4;
  localparam int BUS_DW = 32;
  // word index (byte offset / 4) of each register
  localparam logic [1:0] WIDX_UP   = 2'd0;
  localparam logic [1:0] WIDX_DOWN = 2'd1;
  localparam logic [1:0] WIDX_EJ   = 2'd2;
  localparam logic [1:0] WIDX_RMV  = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FLUSH   = 2'd1,
    ST_REBUILD = 2'd2
  } hp_state_e;
endpackage

// File: rtl/hp_lowbit.sv
module hp_lowbit #(
  parameter int W = 32
) (
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] low_o
);
  // isolate the least significant set bit; zero stays zero
  assign low_o = vec_i & (~vec_i + {{(W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/hp_slot_bank.sv
module hp_slot_bank #(
  parameter int NSLOT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] add_i,
  input  logic [NSLOT-1:0] rm_i,
  input  logic [NSLOT-1:0] cold_i,
  input  logic [NSLOT-1:0] ej_i,
  input  logic             hpen_load_i,
  input  logic [NSLOT-1:0] nonrem_i,
  output logic [NSLOT-1:0] present_o,
  output logic [NSLOT-1:0] pending_o,
  output logic [NSLOT-1:0] hpen_o
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        present_o[s] <= 1'b0;
        pending_o[s] <= 1'b0;
        hpen_o[s]    <= 1'b0;
      end else begin
        // a new arrival wins over a same-cycle eject
        present_o[s] <= add_i[s] | cold_i[s] |
                        (present_o[s] & ~(ej_i[s] & hpen_o[s]));
        // a new removal request wins over a same-cycle eject
        pending_o[s] <= rm_i[s] | (pending_o[s] & ~ej_i[s]);
        if (hpen_load_i) hpen_o[s] <= ~nonrem_i[s];
      end
    end
  end
endmodule

// File: rtl/hp_regif.sv
module hp_regif #(
  parameter int NSLOT = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [hp_pkg::WIN_AW-1:0] bus_addr,
  input  logic [3:0]                bus_be,
  input  logic [hp_pkg::BUS_DW-1:0] bus_wdata,
  input  logic [NSLOT-1:0]          present_i,
  input  logic [NSLOT-1:0]          pending_i,
  input  logic [NSLOT-1:0]          hpen_i,
  output logic [hp_pkg::BUS_DW-1:0] rd_data,
  output logic                      rd_valid,
  output logic                      ej_wr_o,
  output logic [NSLOT-1:0]          ej_mask_o
);
  import hp_pkg::*;

  logic             full_word;
  logic [1:0]       widx;
  logic [BUS_DW-1:0] rd_next;

  assign full_word = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00);
  assign widx      = bus_addr[3:2];
  assign ej_wr_o   = bus_sel && bus_wr && full_word && (widx == WIDX_EJ);
  assign ej_mask_o = bus_wdata[NSLOT-1:0];

  always_comb begin
    rd_next = '0;
    if (full_word) begin
      unique case (widx)
        WIDX_UP:   rd_next[NSLOT-1:0] = present_i & hpen_i;
        WIDX_DOWN: rd_next[NSLOT-1:0] = pending_i;
        WIDX_EJ:   rd_next = '0;
        WIDX_RMV:  rd_next[NSLOT-1:0] = hpen_i;
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl #(
  parameter int NSLOT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic [31:0] hot_add,
  input  logic [31:0] hot_rm,
  input  logic [31:0] cold_plug,
  input  logic [31:0] non_removable,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic [31:0] eject_o,
  output logic        gpe_hp_o
);
  import hp_pkg::*;

  hp_state_e        state_q;
  logic [NSLOT-1:0] present_q, pending_q, hpen_q;
  logic [NSLOT-1:0] low_in, eject_sel, ej_mask;
  logic             ej_wr, busy, hpen_load;
  logic [NSLOT-1:0] add_m, rm_m, cold_m, nonrem_m;

  assign add_m    = hot_add[NSLOT-1:0];
  assign rm_m     = hot_rm[NSLOT-1:0];
  assign cold_m   = cold_plug[NSLOT-1:0];
  assign nonrem_m = non_removable[NSLOT-1:0];

  hp_regif #(.NSLOT(NSLOT)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata),
    .present_i(present_q), .pending_i(pending_q), .hpen_i(hpen_q),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .ej_wr_o(ej_wr), .ej_mask_o(ej_mask)
  );

  // source of the eject candidate: flush walks the pending map,
  // idle serves a firmware write
  always_comb begin
    unique case (state_q)
      ST_FLUSH: low_in = pending_q;
      ST_IDLE:  low_in = ej_wr ? ej_mask : '0;
      default:  low_in = '0;
    endcase
  end

  hp_lowbit #(.W(NSLOT)) u_low (.vec_i(low_in), .low_o(eject_sel));

  assign busy      = (state_q != ST_IDLE);
  assign hpen_load = (state_q == ST_REBUILD);

  hp_slot_bank #(.NSLOT(NSLOT)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .add_i(add_m), .rm_i(rm_m), .cold_i(cold_m), .ej_i(eject_sel),
    .hpen_load_i(hpen_load), .nonrem_i(nonrem_m),
    .present_o(present_q), .pending_o(pending_q), .hpen_o(hpen_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FLUSH;
    end else if (soft_rst) begin
      state_q <= ST_FLUSH;
    end else begin
      unique case (state_q)
        ST_FLUSH:   if (pending_q == '0) state_q <= ST_REBUILD;
        ST_REBUILD: state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  logic [31:0] eject_next;
  always_comb begin
    eject_next = '0;
    eject_next[NSLOT-1:0] = eject_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eject_o  <= '0;
      gpe_hp_o <= 1'b0;
    end else begin
      eject_o  <= eject_next;
      gpe_hp_o <= |(add_m | rm_m);
    end
  end
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk #(
  parameter int NSLOT = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      hot_add,
  input logic [31:0]      hot_rm,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [3:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      rd_data,
  input logic             rd_valid,
  input logic [31:0]      eject_o,
  input logic             gpe_hp_o,
  input logic [NSLOT-1:0] present_q,
  input logic [NSLOT-1:0] pending_q,
  input logic [NSLOT-1:0] hpen_q,
  input logic             busy
);
  assert_eject_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eject_o));

  assert_read_returns_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> rd_valid);

  assert_ej_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[3:2] == 2'd2) |=> (rd_data == 32'd0));

  assert_ej_clears_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((eject_o[NSLOT-1:0] != '0) && ($past(hot_rm[NSLOT-1:0]) == '0))
      |-> ((pending_q & eject_o[NSLOT-1:0]) == '0));

  assert_nonrem_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (((($past(present_q & ~hpen_q)) & eject_o[NSLOT-1:0]) != '0))
      |-> ((present_q & eject_o[NSLOT-1:0]) != '0));

  assert_gpe_on_add_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_add[NSLOT-1:0] != '0) |=> gpe_hp_o);

  assert_gpe_on_rm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_rm[NSLOT-1:0] != '0) |=> gpe_hp_o);

  assert_cold_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((hot_add[NSLOT-1:0] == '0) && (hot_rm[NSLOT-1:0] == '0)) |=> !gpe_hp_o);

  assert_zero_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && bus_sel && bus_wr && bus_wdata[NSLOT-1:0] == '0) |=> (eject_o == 32'd0));
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk #(.NSLOT(NSLOT)) u_chk (.*);

// File: tb/tb_hp_slot_ctrl.sv
module tb_hp_slot_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [31:0] hot_add = '0, hot_rm = '0, cold_plug = '0;
  logic [31:0] non_removable = 32'h3;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0, bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data, eject_o;
  logic        rd_valid, gpe_hp_o;

  hp_slot_ctrl dut (.*);

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [31:0] q_rd[$];   string q_rdtag[$];
  logic [31:0] q_ej[$];   string q_ejtag[$];
  int          q_gpe = 0;
  logic [31:0] m_present = '0, m_pending = '0, m_hpen = '0;
  bit          done = 0;

  function automatic logic [31:0] low1(logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

  task automatic fail_msg(string tag, logic [31:0] act, logic [31:0] exp);
    nfail++;
    $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) if (rst_n && !done) begin
    if (eject_o != 0) begin
      nchk++;
      if (q_ej.size() == 0) fail_msg("R12 unexpected eject", eject_o, 32'd0);
      else begin
        logic [31:0] e; string t;
        e = q_ej.pop_front(); t = q_ejtag.pop_front();
        if (eject_o !== e) fail_msg(t, eject_o, e);
      end
    end
    if (gpe_hp_o) begin
      nchk++;
      if (q_gpe == 0) fail_msg("R9 unexpected gpe", 32'd1, 32'd0);
      else q_gpe--;
    end
    if (rd_valid) begin
      nchk++;
      if (q_rd.size() == 0) fail_msg("R1 unexpected rd_valid", rd_data, 32'd0);
      else begin
        logic [31:0] e; string t;
        e = q_rd.pop_front(); t = q_rdtag.pop_front();
        if (rd_data !== e) fail_msg(t, rd_data, e);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_rd(logic [3:0] a, logic [3:0] be, logic [31:0] exp, string tag);
    q_rd.push_back(exp); q_rdtag.push_back(tag);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = be;
    @(posedge clk); #1;
    bus_sel = 0; bus_be = 4'hF;
    idle(1);
  endtask

  // effect=1: the bench model applies the eject rule
  task automatic bus_wrt(logic [3:0] a, logic [3:0] be, logic [31:0] d, bit effect, string tag);
    if (effect && a == 4'h8 && be == 4'hF && d != 0) begin
      logic [31:0] l;
      l = low1(d);
      q_ej.push_back(l); q_ejtag.push_back(tag);
      m_pending &= ~l;
      if ((m_hpen & l) != 0) m_present &= ~l;
    end
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; bus_be = 4'hF;
    idle(1);
  endtask

  task automatic events(logic [31:0] a, logic [31:0] r, logic [31:0] c);
    if ((a | r) != 0) q_gpe++;
    m_present |= a | c;
    m_pending |= r;
    @(posedge clk); #1;
    hot_add = a; hot_rm = r; cold_plug = c;
    @(posedge clk); #1;
    hot_add = '0; hot_rm = '0; cold_plug = '0;
    idle(1);
  endtask

  task automatic check_regs(string tag);
    bus_rd(4'h0, 4'hF, m_present & m_hpen, {tag, " R2 up"});
    bus_rd(4'h4, 4'hF, m_pending,          {tag, " R3 down"});
    bus_rd(4'hC, 4'hF, m_hpen,             {tag, " R6 removable"});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(4);
    m_hpen = ~non_removable;
    check_regs("reset R10");

    events('0, '0, 32'h13);                 // R9 cold plug, no gpe
    bus_rd(4'h0, 4'hF, 32'h10, "R9 R2 cold present");
    events(32'h80, '0, '0);                 // R7
    bus_rd(4'h0, 4'hF, 32'h90, "R7 hot add present");
    events('0, 32'h290, '0);                // R8
    bus_rd(4'h4, 4'hF, 32'h290, "R8 pending set");

    bus_wrt(4'h8, 4'hF, 32'h0, 1, "R11");   // zero mask
    bus_rd(4'h4, 4'hF, 32'h290, "R11 pending unchanged");
    bus_wrt(4'h8, 4'hF, 32'h280, 1, "R4 lowest bit eject");
    check_regs("R4 after eject");
    bus_rd(4'h8, 4'hF, 32'h0, "R4 eject reads zero");

    events('0, 32'h2, '0);
    bus_wrt(4'h8, 4'hF, 32'h2, 1, "R5 nonremovable eject");
    check_regs("R5 after eject");

    bus_wrt(4'h0, 4'hF, 32'hFFFF_FFFF, 0, "R6");
    bus_wrt(4'h4, 4'hF, 32'hFFFF_FFFF, 0, "R6");
    bus_wrt(4'hC, 4'hF, 32'hFFFF_FFFF, 0, "R6");
    check_regs("R6 ignored writes");

    bus_wrt(4'h8, 4'h3, 32'h10, 0, "R1 partial");
    bus_wrt(4'h9, 4'hF, 32'h10, 0, "R1 misaligned");
    bus_rd(4'h4, 4'h3, 32'h0, "R1 partial read zero");
    bus_rd(4'h5, 4'hF, 32'h0, "R1 misaligned read zero");
    check_regs("R1 after bad writes");

    // R10: flush pending {4,9} lowest first; write during flush ignored
    non_removable = 32'h1;
    q_ej.push_back(32'h10);  q_ejtag.push_back("R10 flush first");
    q_ej.push_back(32'h200); q_ejtag.push_back("R10 flush second");
    m_present &= ~(m_hpen & 32'h210);
    m_pending = '0;
    @(posedge clk); #1 soft_rst = 1;
    @(posedge clk); #1 soft_rst = 0;
    bus_sel = 1; bus_wr = 1; bus_addr = 4'h8; bus_be = 4'hF; bus_wdata = 32'h1;
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0;
    idle(6);
    m_hpen = ~non_removable;
    check_regs("R10 R5 after flush");       // slot1 now visible as present

    idle(3);
    nchk++;
    if (q_ej.size() != 0 || q_rd.size() != 0 || q_gpe != 0)
      fail_msg("R12 missing results", q_ej.size() + q_rd.size(), 32'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    nchk++;
    fail_msg("R12 watchdog", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule